// File: doc/BRIEF.md
# Strided Interleave Transfer Sequencer

This block produces the address stream for a chunked copy between a small linear scratch memory and main memory. Software supplies a total quadword count, a start address on each side, a direction and a packed stride word that holds a chunk (transfer) length and a skip length. The sequencer then emits one source/destination address pair per quadword. Main memory is visited in chunks separated by gaps of `skip` quadwords. The scratch side is packed densely.

The block moves no data. A downstream engine takes each address pair when `ready` is high, performs the quadword move and lets the sequencer advance. When the last pair has been accepted, the sequencer pulses `done`, its remaining-count output reads zero, and it accepts a new `start`.

Top module: `stride_seq`

## Requirements
- R1: The stride word supplies the skip length in bits 7:0 and the transfer length in bits 23:16. All other bits of the stride word have no effect.
- R2: A transfer length of zero makes the whole total count a single chunk, so no skip is ever inserted.
- R3: Within a chunk, consecutive accepted quadwords advance both the main and scratch addresses by 16 bytes. Each chunk holds min(transfer length, remaining) quadwords.
- R4: From the last quadword of one chunk to the first quadword of the next, the main address grows by (skip+1)×16 bytes and the scratch address grows by 16 bytes only.
- R5: With `dir`=0 the source is main memory and the destination is scratch. With `dir`=1 the source is scratch and the destination is main memory. The scratch address is zero-extended.
- R6: Scratch addresses wrap modulo 2^SPAD_W bytes (16 KB by default).
- R7: `start` with a total of zero pulses `done` in the next cycle and never raises `out_valid`.
- R8: While `ready` is low, `out_valid`, `src_addr` and `dst_addr` hold their values.
- R9: `done` is a one-cycle pulse in the cycle after the last pair is accepted. In that cycle `remaining` reads zero and `busy` is low.
- R10: A `start` that arrives while `busy` is high is ignored, and so are any input changes made during the run.
- R11: `start` with a nonzero total raises `out_valid` in the next cycle. Exactly total pairs are then issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| dir | input | 1 | 0: main to scratch, 1: scratch to main |
| total_qwc | input | QWC_W | Total quadwords to sequence |
| main_start | input | ADDR_W | Main-memory byte start address |
| spad_start | input | SPAD_W | Scratch byte start address |
| stride | input | 32 | Packed skip (7:0) and transfer length (23:16) |
| ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | Address pair is valid |
| src_addr | output | ADDR_W | Source byte address |
| dst_addr | output | ADDR_W | Destination byte address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| remaining | output | QWC_W | Quadwords not yet accepted |

## Verification
The bench builds the default parameters (16-bit count, 32-bit main address, 14-bit scratch address). It sweeps every combination of total count 0 to 9, transfer length 0 to 4, skip 0 to 3 and both directions. This range reaches totals below, equal to and above the chunk length, including partial final chunks and the single-chunk case where the length is zero. Some runs place the scratch start 32 bytes below the 16 KB boundary so that the wrap is exercised. Three `ready` patterns exercise the hold behaviour. One family of runs raises `start` again mid-run with scrambled inputs.

// File: rtl/siseq_pkg.sv
package siseq_pkg;
  localparam int QW_BYTES = 16;
  localparam int QW_SHIFT = 4;
  localparam int FIELD_W  = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] skip;
    logic [FIELD_W-1:0] tlen;
  } stride_t;

  function automatic stride_t unpack_stride(input logic [31:0] word);
    stride_t s;
    s.skip = word[7:0];
    s.tlen = word[23:16];
    return s;
  endfunction
endpackage

// File: rtl/siseq_count.sv
module siseq_count
  import siseq_pkg::*;
#(
  parameter int QWC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [QWC_W-1:0]   total,
  input  logic [FIELD_W-1:0] tlen,
  input  logic               step,
  output logic [QWC_W-1:0]   rem,
  output logic               chunk_end
);
  logic [QWC_W-1:0] clen_q;
  logic [QWC_W-1:0] tlen_q;
  logic [QWC_W-1:0] eff_len;

  always_comb begin
    eff_len = (tlen == '0) ? total : QWC_W'(tlen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      clen_q <= '0;
      tlen_q <= '0;
    end else if (load) begin
      rem    <= total;
      clen_q <= eff_len;
      tlen_q <= eff_len;
    end else if (step) begin
      rem    <= rem - QWC_W'(1);
      clen_q <= (clen_q == QWC_W'(1)) ? tlen_q : clen_q - QWC_W'(1);
    end
  end

  assign chunk_end = (clen_q == QWC_W'(1));
endmodule

// File: rtl/siseq_addr.sv
module siseq_addr
  import siseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPAD_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  main_in,
  input  logic [SPAD_W-1:0]  spad_in,
  input  logic [FIELD_W-1:0] skip_in,
  input  logic               step,
  input  logic               chunk_end,
  output logic [ADDR_W-1:0]  main_q,
  output logic [SPAD_W-1:0]  spad_q
);
  logic [FIELD_W-1:0] skip_q;
  logic [ADDR_W-1:0]  gap;

  always_comb begin
    gap = chunk_end ? (ADDR_W'(skip_q) << QW_SHIFT) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      spad_q <= '0;
      skip_q <= '0;
    end else if (load) begin
      main_q <= main_in;
      spad_q <= spad_in;
      skip_q <= skip_in;
    end else if (step) begin
      main_q <= main_q + ADDR_W'(QW_BYTES) + gap;
      spad_q <= spad_q + SPAD_W'(QW_BYTES);
    end
  end
endmodule

// File: rtl/stride_seq.sv
module stride_seq
  import siseq_pkg::*;
#(
  parameter int QWC_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SPAD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic [QWC_W-1:0]  total_qwc,
  input  logic [ADDR_W-1:0] main_start,
  input  logic [SPAD_W-1:0] spad_start,
  input  logic [31:0]       stride,
  input  logic              ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              done,
  output logic [QWC_W-1:0]  remaining
);
  stride_t           fields;
  logic              load;
  logic              step;
  logic              chunk_end;
  logic              dir_q;
  logic [ADDR_W-1:0] main_q;
  logic [SPAD_W-1:0] spad_q;
  logic [ADDR_W-1:0] spad_ext;

  assign fields    = unpack_stride(stride);
  assign busy      = (remaining != '0);
  assign out_valid = busy;
  assign load      = start & ~busy;
  assign step      = out_valid & ready;
  assign spad_ext  = ADDR_W'(spad_q);

  siseq_count #(.QWC_W(QWC_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .total     (total_qwc),
    .tlen      (fields.tlen),
    .step      (step),
    .rem       (remaining),
    .chunk_end (chunk_end)
  );

  siseq_addr #(.ADDR_W(ADDR_W), .SPAD_W(SPAD_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .main_in   (main_start),
    .spad_in   (spad_start),
    .skip_in   (fields.skip),
    .step      (step),
    .chunk_end (chunk_end),
    .main_q    (main_q),
    .spad_q    (spad_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (load) dir_q <= dir;
      done <= (load && total_qwc == '0) || (step && remaining == QWC_W'(1));
    end
  end

  always_comb begin
    if (dir_q) begin
      src_addr = spad_ext;
      dst_addr = main_q;
    end else begin
      src_addr = main_q;
      dst_addr = spad_ext;
    end
  end
endmodule

// File: rtl/stride_seq_chk.sv
module stride_seq_chk #(
  parameter int QWC_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [QWC_W-1:0]  total_qwc,
  input logic              ready,
  input logic              out_valid,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              busy,
  input logic              done,
  input logic [QWC_W-1:0]  remaining
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ready) |=> (out_valid && $stable(src_addr) && $stable(dst_addr)));

  assert_zero_total_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && total_qwc == '0) |=> (done && !out_valid));

  assert_first_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && total_qwc != '0) |=> out_valid);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (remaining == '0 && !busy && !out_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(ready && remaining == QWC_W'(1))) |=> busy);
endmodule

bind stride_seq stride_seq_chk #(.QWC_W(QWC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .total_qwc (total_qwc),
  .ready     (ready),
  .out_valid (out_valid),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .busy      (busy),
  .done      (done),
  .remaining (remaining)
);

// File: tb/sim_stride_seq.sv
module sim_stride_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [15:0] total_qwc = '0;
  logic [31:0] main_start = '0;
  logic [13:0] spad_start = '0;
  logic [31:0] stride = '0;
  logic        ready = 1'b0;
  logic        out_valid;
  logic [31:0] src_addr;
  logic [31:0] dst_addr;
  logic        busy;
  logic        done;
  logic [15:0] remaining;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  stride_seq u0 (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .total_qwc(total_qwc),
    .main_start(main_start), .spad_start(spad_start), .stride(stride),
    .ready(ready), .out_valid(out_valid), .src_addr(src_addr),
    .dst_addr(dst_addr), .busy(busy), .done(done), .remaining(remaining)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Stride bits outside 7:0 and 23:16 are filled with junk in every run (R1).
  task automatic run(input int tot, input int tl, input int sk, input bit d,
                     input int mode, input bit poke, input logic [13:0] sp0);
    logic [31:0] m0;
    logic [31:0] me;
    logic [31:0] se;
    logic [31:0] exp_src;
    logic [31:0] exp_dst;
    int tf;
    int k;
    int cyc;
    bit held;
    string mtag;
    string stag;
    m0   = 32'h2000_0000 + 32'(tot) * 32'h100 + 32'(sk) * 32'h10000;
    tf   = (tl == 0) ? tot : tl;
    k    = 0;
    cyc  = 0;
    held = 1'b0;
    @(negedge clk);
    start      = 1'b1;
    dir        = d;
    total_qwc  = 16'(tot);
    main_start = m0;
    spad_start = sp0;
    stride     = {8'hA5, 8'(tl), 8'h5A, 8'(sk)};
    ready      = 1'b0;
    @(negedge clk);
    start      = 1'b0;
    total_qwc  = 16'hFFFF;
    stride     = 32'hFFFF_FFFF;
    dir        = ~d;
    main_start = 32'hDEAD_0000;
    if (tot == 0) begin
      chk(done && !out_valid, "R7 done/valid", {30'd0, done, out_valid}, 32'h2);
    end else begin
      while (k < tot) begin
        start = (poke && cyc == 2);
        chk(out_valid == 1'b1, "R11 valid", {31'd0, out_valid}, 32'h1);
        me = m0 + 32'(16 * (k + sk * (k / tf)));
        se = 32'((32'(sp0) + 32'(16 * k)) & 32'h3FFF);
        exp_src = d ? se : me;
        exp_dst = d ? me : se;
        if (poke) mtag = "R10 main";
        else if (tl == 0) mtag = "R2 main";
        else if (k > 0 && k % tf == 0) mtag = "R4 R1 main";
        else mtag = "R3 main";
        if (32'(sp0) + 32'(16 * k) >= 32'h4000) stag = "R6 scratch";
        else if (held) stag = "R8 scratch";
        else stag = "R5 scratch";
        chk((d ? dst_addr : src_addr) == me, mtag, d ? dst_addr : src_addr, me);
        chk((d ? src_addr : dst_addr) == se, stag, d ? src_addr : dst_addr, se);
        chk(src_addr == exp_src, "R5 src", src_addr, exp_src);
        case (mode)
          0:       ready = 1'b1;
          1:       ready = cyc[0];
          default: ready = (cyc % 3 != 2);
        endcase
        held = !ready;
        if (ready) k++;
        cyc++;
        @(negedge clk);
      end
      start = 1'b0;
      chk(done && !out_valid && !busy && remaining == 16'd0, "R9 finish",
          {15'd0, remaining, done}, 32'h1);
    end
    ready = 1'b0;
    @(negedge clk);
    chk(!done && !out_valid, "R9 pulse", {30'd0, done, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy && !done && remaining == 16'd0, "R9 reset",
        {15'd0, remaining, done}, 32'h0);
    for (int tot = 0; tot < 10; tot++)
      for (int tl = 0; tl < 5; tl++)
        for (int sk = 0; sk < 4; sk++)
          for (int d = 0; d < 2; d++)
            run(tot, tl, sk, d[0], (tot + tl + sk) % 3, (tot == 7 && sk == 1),
                (tl == 3) ? 14'h3FE0 : 14'h0100 + 14'(sk * 16'h40));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule